// File: doc/BRIEF.md
# Field-Selected BCD Register ALU

This block is the decimal datapath of a register-oriented floating-point sequencer. Each request carries three 56-bit operand words (A, B and C, fourteen BCD nibbles each), an operation code, a field-select code and a 4-bit immediate. The block computes one operation over a contiguous range of nibbles and returns the destination word. Nibbles inside the range take the new value. Nibbles outside it keep the destination's old value. It also returns a carry/borrow flag and a condition flag. The nibble range comes from the field-select code and from a pointer register held inside the block.

The word layout is as follows. The exponent sits in nibbles 1..0, the exponent sign in nibble 2, the ten-digit mantissa in nibbles 12..3 and the mantissa sign in nibble 13. A sign nibble holds 0 for positive and 9 for negative. Arithmetic is decimal: when a digit sum exceeds 9, 6 is added. The carry runs upward from the lowest selected nibble and leaves at the highest selected nibble.

Requests and results use valid/ready handshakes. A request is taken in a cycle where `req_valid` and `req_ready` are both high. Its result appears registered on the next clock edge. The result stays on the outputs, unchanged, for as long as `res_ready` is low. While a result waits, `req_ready` stays low, so back-pressure reaches the request side in the same cycle. Instruction fetch and sequencing belong to the surrounding controller.

Top module: `bcd_field_alu`

## Requirements
- R1: Field codes on `req_fs` select these nibble ranges: 0 = nibble at pointer only, 1 = nibbles 0 through pointer, 2 = nibble 2, 3 = nibbles 1..0, 4 = nibble 13, 5 = nibbles 12..3, 6 = nibbles 13..3, 7 = all 14 nibbles. Operation codes on `req_op`: 0 no-op, 1 clear, 2 copy, 3 A+B→A, 4 A+C→A, 5 A+C→C, 6 C+C→C, 7 A−B→A, 8 A−C→A, 9 A−C→C, 10 A+1→A, 11 C+1→C, 12 A−1→A, 13 C−1→C, 14 0−C→C, 15 0−C−1→C, 16 shift right, 17 shift A left, 18 field is zero, 19 A≥C, 20 A≥B, 21 field is nonzero, 22 pointer set, 23 pointer increment, 24 pointer decrement, 25 pointer differs, 26 load digit. Where an operation names a register through `req_imm[1:0]`, 0 is A, 1 is B, and 2 or 3 is C.
- R2: Additions and increments produce the decimal sum of the selected digits. The carry enters at the lowest selected nibble and moves upward. The carry out of the highest selected nibble appears on `res_carry`.
- R3: Subtractions, decrements and both negations produce the ten's-complement decimal difference over the field. `res_carry` is 1 when a borrow leaves the highest selected nibble.
- R4: Result nibbles outside the selected field equal the destination register's input nibbles.
- R5: Shift right (register chosen by `req_imm`) and shift left of A move digits one nibble within the field only. The vacated end nibble is filled with 0, and `res_carry` is 0.
- R6: Clear writes 0 into the field of the register chosen by `req_imm`. Copy writes the field of a source into a destination. `req_imm` selects the pair: 0 is A→B, 1 is B→C, 2 or 3 is C→A.
- R7: The four tests return the tested register unchanged on `res_word` with `res_carry` 0. The A≥C and A≥B tests return A. The zero and nonzero tests return the register chosen by `req_imm`. `res_cond` is 1 exactly when the test holds over the field.
- R8: Load digit writes `req_imm` into nibble P of C and then decrements the pointer. It ignores `req_fs`.
- R9: Pointer set loads `req_imm` when it is 0..13 and is ignored when it is 14 or 15. Increment wraps from 13 to 0. Decrement and load digit wrap from 0 to 13. `ptr` shows the current value.
- R10: Pointer differs sets `res_cond` to 1 exactly when the pointer is not equal to `req_imm`. The no-op and all pointer operations return C unchanged.
- R11: `req_ready` is high when no result waits or `res_ready` is high. An accepted request raises `res_valid` on the next edge. A stalled result keeps `res_word`, `res_carry` and `res_cond` stable.
- R12: After reset, `res_valid` is 0, `ptr` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_op | input | 5 | Operation code |
| req_fs | input | 3 | Field-select code |
| req_imm | input | 4 | Digit, pointer value or register choice |
| req_a | input | 56 | Operand word A |
| req_b | input | 56 | Operand word B |
| req_c | input | 56 | Operand word C |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_word | output | 56 | Destination word after the operation |
| res_carry | output | 1 | Carry or borrow out of the field |
| res_cond | output | 1 | Test outcome |
| ptr | output | 4 | Current nibble pointer |

## Verification
The bench builds the block with its default layout: ten mantissa digits and two exponent digits, fourteen nibbles in all. With this layout a carry can ripple across the full word, every named field lands on its real nibble boundary, and the pointer reaches its wrap points at 13 and 0. Pointer values 14 and 15 can be encoded but are out of range, so they exercise the ignored-set rule.

// File: rtl/bfa_pkg.sv
package bfa_pkg;
  typedef enum logic [4:0] {
    OP_NOP      = 5'd0,
    OP_ZERO     = 5'd1,
    OP_COPY     = 5'd2,
    OP_ADD_AB_A = 5'd3,
    OP_ADD_AC_A = 5'd4,
    OP_ADD_AC_C = 5'd5,
    OP_ADD_CC_C = 5'd6,
    OP_SUB_AB_A = 5'd7,
    OP_SUB_AC_A = 5'd8,
    OP_SUB_AC_C = 5'd9,
    OP_INC_A    = 5'd10,
    OP_INC_C    = 5'd11,
    OP_DEC_A    = 5'd12,
    OP_DEC_C    = 5'd13,
    OP_NEG_C    = 5'd14,
    OP_NEGM1_C  = 5'd15,
    OP_SHR      = 5'd16,
    OP_SHL_A    = 5'd17,
    OP_TST_Z    = 5'd18,
    OP_GE_AC    = 5'd19,
    OP_GE_AB    = 5'd20,
    OP_TST_NZ   = 5'd21,
    OP_P_SET    = 5'd22,
    OP_P_INC    = 5'd23,
    OP_P_DEC    = 5'd24,
    OP_P_NE     = 5'd25,
    OP_LDC      = 5'd26
  } op_e;

  typedef enum logic [2:0] {
    FS_P  = 3'd0,
    FS_WP = 3'd1,
    FS_XS = 3'd2,
    FS_X  = 3'd3,
    FS_S  = 3'd4,
    FS_M  = 3'd5,
    FS_MS = 3'd6,
    FS_W  = 3'd7
  } fs_e;

  typedef enum logic [2:0] {
    K_NONE, K_ARITH, K_SHR, K_SHL, K_ZERO, K_COPY, K_LDC
  } kind_e;
endpackage

// File: rtl/bfa_field_mask.sv
module bfa_field_mask #(
  parameter int NIB   = 14,
  parameter int EXP_D = 2,
  parameter int PW    = 4
) (
  input  logic [2:0]    fs,
  input  logic [PW-1:0] ptr,
  output logic [NIB-1:0] sel
);
  import bfa_pkg::*;
  localparam int XS_POS = EXP_D;
  localparam int M_LO   = EXP_D + 1;
  localparam int M_HI   = NIB - 2;
  localparam int S_POS  = NIB - 1;

  int lo, hi;

  always_comb begin
    lo = 0;
    hi = NIB - 1;
    unique case (fs_e'(fs))
      FS_P:  begin lo = int'(ptr); hi = int'(ptr); end
      FS_WP: begin lo = 0;         hi = int'(ptr); end
      FS_XS: begin lo = XS_POS;    hi = XS_POS;    end
      FS_X:  begin lo = 0;         hi = EXP_D - 1; end
      FS_S:  begin lo = S_POS;     hi = S_POS;     end
      FS_M:  begin lo = M_LO;      hi = M_HI;      end
      FS_MS: begin lo = M_LO;      hi = S_POS;     end
      default: begin lo = 0;       hi = NIB - 1;   end
    endcase
    for (int i = 0; i < NIB; i++) begin
      sel[i] = (i >= lo) && (i <= hi);
    end
  end
endmodule

// File: rtl/bfa_bcd_chain.sv
module bfa_bcd_chain #(
  parameter int NIB = 14
) (
  input  logic [4*NIB-1:0] x,
  input  logic [4*NIB-1:0] y,
  input  logic             sub,
  input  logic             cin,
  input  logic [NIB-1:0]   sel,
  output logic [4*NIB-1:0] sum,
  output logic             cout
);
  logic [NIB:0] c;
  assign c[0] = cin;

  for (genvar i = 0; i < NIB; i++) begin : g_dig
    logic [3:0] xd, yd, yo;
    logic [4:0] s;
    logic       gt;
    assign xd = x[4*i +: 4];
    assign yd = y[4*i +: 4];
    assign yo = sub ? (4'd9 - yd) : yd;
    assign s  = {1'b0, xd} + {1'b0, yo} + {4'b0, c[i]};
    assign gt = (s > 5'd9);
    assign sum[4*i +: 4] = gt ? (s[3:0] + 4'd6) : s[3:0];
    assign c[i+1] = sel[i] ? gt : c[i];
  end

  assign cout = c[NIB];
endmodule

// File: rtl/bfa_shifter.sv
module bfa_shifter #(
  parameter int NIB = 14
) (
  input  logic [4*NIB-1:0] w,
  input  logic [NIB-1:0]   sel,
  input  logic             left,
  output logic [4*NIB-1:0] o
);
  for (genvar i = 0; i < NIB; i++) begin : g_nib
    logic [3:0] from_hi, from_lo;
    if (i < NIB - 1) begin : g_hi
      assign from_hi = sel[i+1] ? w[4*(i+1) +: 4] : 4'd0;
    end else begin : g_top
      assign from_hi = 4'd0;
    end
    if (i > 0) begin : g_lo
      assign from_lo = sel[i-1] ? w[4*(i-1) +: 4] : 4'd0;
    end else begin : g_bot
      assign from_lo = 4'd0;
    end
    assign o[4*i +: 4] = left ? from_lo : from_hi;
  end
endmodule

// File: rtl/bfa_ptr_unit.sv
module bfa_ptr_unit #(
  parameter int NIB = 14,
  parameter int PW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          do_set,
  input  logic          do_inc,
  input  logic          do_dec,
  input  logic [PW-1:0] set_val,
  output logic [PW-1:0] ptr
);
  localparam logic [PW-1:0] TOP = PW'(NIB - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (do_set) begin
      if (set_val <= TOP) ptr <= set_val;
    end else if (do_inc) begin
      ptr <= (ptr == TOP) ? '0 : ptr + 1'b1;
    end else if (do_dec) begin
      ptr <= (ptr == '0) ? TOP : ptr - 1'b1;
    end
  end
endmodule

// File: rtl/bcd_field_alu.sv
module bcd_field_alu #(
  parameter int MANT_D = 10,
  parameter int EXP_D  = 2,
  parameter int PW     = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [4:0]  req_op,
  input  logic [2:0]  req_fs,
  input  logic [3:0]  req_imm,
  input  logic [55:0] req_a,
  input  logic [55:0] req_b,
  input  logic [55:0] req_c,
  output logic        res_valid,
  input  logic        res_ready,
  output logic [55:0] res_word,
  output logic        res_carry,
  output logic        res_cond,
  output logic [3:0]  ptr
);
  import bfa_pkg::*;
  localparam int NIB = MANT_D + EXP_D + 2;
  localparam int W   = 4 * NIB;

  op_e          op;
  kind_e        kind;
  logic [W-1:0] x, y, base, src, newv, sum, shv, bitmask, merged;
  logic         sub, cin, cout, shl, cond;
  logic [NIB-1:0] fsel, psel, esel;
  logic [PW-1:0]  p_q;
  logic         acc;

  assign op  = op_e'(req_op);
  assign acc = req_valid && req_ready;
  assign req_ready = !res_valid || res_ready;

  function automatic logic [W-1:0] pick(input logic [1:0] s,
      input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c);
    case (s)
      2'd0:    return a;
      2'd1:    return b;
      default: return c;
    endcase
  endfunction

  bfa_field_mask #(.NIB(NIB), .EXP_D(EXP_D), .PW(PW)) u_mask (
    .fs(req_fs), .ptr(p_q), .sel(fsel)
  );

  bfa_bcd_chain #(.NIB(NIB)) u_chain (
    .x(x), .y(y), .sub(sub), .cin(cin), .sel(fsel), .sum(sum), .cout(cout)
  );

  bfa_shifter #(.NIB(NIB)) u_shift (
    .w(base), .sel(fsel), .left(shl), .o(shv)
  );

  bfa_ptr_unit #(.NIB(NIB), .PW(PW)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .do_set(acc && op == OP_P_SET),
    .do_inc(acc && op == OP_P_INC),
    .do_dec(acc && (op == OP_P_DEC || op == OP_LDC)),
    .set_val(req_imm[PW-1:0]),
    .ptr(p_q)
  );

  // decode: operands, destination and result kind
  always_comb begin
    kind = K_NONE;
    x    = req_a;
    y    = '0;
    sub  = 1'b0;
    cin  = 1'b0;
    base = req_c;
    src  = '0;
    shl  = 1'b0;
    cond = 1'b0;
    unique case (op)
      OP_ZERO:     begin kind = K_ZERO; base = pick(req_imm[1:0], req_a, req_b, req_c); end
      OP_COPY: begin
        kind = K_COPY;
        case (req_imm[1:0])
          2'd0:    begin src = req_a; base = req_b; end
          2'd1:    begin src = req_b; base = req_c; end
          default: begin src = req_c; base = req_a; end
        endcase
      end
      OP_ADD_AB_A: begin kind = K_ARITH; y = req_b; base = req_a; end
      OP_ADD_AC_A: begin kind = K_ARITH; y = req_c; base = req_a; end
      OP_ADD_AC_C: begin kind = K_ARITH; y = req_c; base = req_c; end
      OP_ADD_CC_C: begin kind = K_ARITH; x = req_c; y = req_c; base = req_c; end
      OP_SUB_AB_A: begin kind = K_ARITH; y = req_b; sub = 1'b1; cin = 1'b1; base = req_a; end
      OP_SUB_AC_A: begin kind = K_ARITH; y = req_c; sub = 1'b1; cin = 1'b1; base = req_a; end
      OP_SUB_AC_C: begin kind = K_ARITH; y = req_c; sub = 1'b1; cin = 1'b1; base = req_c; end
      OP_INC_A:    begin kind = K_ARITH; cin = 1'b1; base = req_a; end
      OP_INC_C:    begin kind = K_ARITH; x = req_c; cin = 1'b1; base = req_c; end
      OP_DEC_A:    begin kind = K_ARITH; sub = 1'b1; base = req_a; end
      OP_DEC_C:    begin kind = K_ARITH; x = req_c; sub = 1'b1; base = req_c; end
      OP_NEG_C:    begin kind = K_ARITH; x = '0; y = req_c; sub = 1'b1; cin = 1'b1; base = req_c; end
      OP_NEGM1_C:  begin kind = K_ARITH; x = '0; y = req_c; sub = 1'b1; base = req_c; end
      OP_SHR:      begin kind = K_SHR; base = pick(req_imm[1:0], req_a, req_b, req_c); end
      OP_SHL_A:    begin kind = K_SHL; shl = 1'b1; base = req_a; end
      OP_TST_Z: begin
        base = pick(req_imm[1:0], req_a, req_b, req_c);
        cond = ~|(base & bitmask);
      end
      OP_TST_NZ: begin
        base = pick(req_imm[1:0], req_a, req_b, req_c);
        cond = |(base & bitmask);
      end
      OP_GE_AC:    begin y = req_c; sub = 1'b1; cin = 1'b1; base = req_a; cond = cout; end
      OP_GE_AB:    begin y = req_b; sub = 1'b1; cin = 1'b1; base = req_a; cond = cout; end
      OP_P_NE:     begin cond = (p_q != req_imm[PW-1:0]); end
      OP_LDC:      begin kind = K_LDC; end
      default:     begin kind = K_NONE; end
    endcase
  end

  // value written into the selected nibbles
  always_comb begin
    unique case (kind)
      K_ARITH:       newv = sum;
      K_SHR, K_SHL:  newv = shv;
      K_COPY:        newv = src;
      K_LDC:         newv = {NIB{req_imm}};
      default:       newv = '0;
    endcase
  end

  for (genvar i = 0; i < NIB; i++) begin : g_sel
    assign psel[i] = (p_q == PW'(i));
    assign esel[i] = (kind == K_NONE) ? 1'b0 : ((kind == K_LDC) ? psel[i] : fsel[i]);
    assign bitmask[4*i +: 4] = {4{fsel[i]}};
    assign merged[4*i +: 4]  = esel[i] ? newv[4*i +: 4] : base[4*i +: 4];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_word  <= '0;
      res_carry <= 1'b0;
      res_cond  <= 1'b0;
    end else if (acc) begin
      res_valid <= 1'b1;
      res_word  <= merged;
      res_carry <= (kind == K_ARITH) ? (sub ? ~cout : cout) : 1'b0;
      res_cond  <= cond;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  assign ptr = p_q;
endmodule

// File: rtl/bcd_field_alu_chk.sv
module bcd_field_alu_chk #(
  parameter int MANT_D = 10,
  parameter int EXP_D  = 2,
  parameter int PW     = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [4:0]  req_op,
  input logic [2:0]  req_fs,
  input logic [55:0] req_a,
  input logic        res_valid,
  input logic        res_ready,
  input logic [55:0] res_word,
  input logic        res_carry,
  input logic        res_cond,
  input logic [3:0]  ptr
);
  import bfa_pkg::*;
  localparam int NIB = MANT_D + EXP_D + 2;
  localparam int XSB = 4 * EXP_D;
  localparam logic [PW-1:0] TOP = PW'(NIB - 1);

  logic acc;
  assign acc = req_valid && req_ready;

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_word) && $stable(res_carry) && $stable(res_cond));

  assert_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> res_valid);

  assert_ptr_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= TOP);

  assert_ptr_inc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_op == OP_P_INC |=> ptr == (($past(ptr) == TOP) ? '0 : $past(ptr) + 1'b1));

  assert_keep_outside_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_op == OP_ADD_AB_A && req_fs == FS_XS |=>
      res_word[55:XSB+4] == $past(req_a[55:XSB+4]) && res_word[XSB-1:0] == $past(req_a[XSB-1:0]));

  assert_test_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (req_op == OP_GE_AC || req_op == OP_GE_AB) |=> !res_carry && res_word == $past(req_a));
endmodule

bind bcd_field_alu bcd_field_alu_chk #(.MANT_D(MANT_D), .EXP_D(EXP_D), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .req_fs(req_fs), .req_a(req_a), .res_valid(res_valid),
  .res_ready(res_ready), .res_word(res_word), .res_carry(res_carry),
  .res_cond(res_cond), .ptr(ptr)
);

// File: tb/sim_bcd_field_alu.sv
`timescale 1ns/1ps
module sim_bcd_field_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [4:0]  req_op = '0;
  logic [2:0]  req_fs = '0;
  logic [3:0]  req_imm = '0;
  logic [55:0] req_a = '0, req_b = '0, req_c = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [55:0] res_word;
  logic        res_carry, res_cond;
  logic [3:0]  ptr;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bcd_field_alu u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_fs(req_fs), .req_imm(req_imm),
    .req_a(req_a), .req_b(req_b), .req_c(req_c),
    .res_valid(res_valid), .res_ready(res_ready), .res_word(res_word),
    .res_carry(res_carry), .res_cond(res_cond), .ptr(ptr)
  );

  // {op, fs, imm, a, b, c, expected word, carry, cond, ptr after}
  typedef logic [241:0] vec_t;
  localparam int NV = 24;
  localparam vec_t TBL [NV] = '{
    {5'd22, 3'd7, 4'd5, 56'h0, 56'h0, 56'h12345678901234, 56'h12345678901234, 1'b0, 1'b0, 4'd5},
    {5'd3,  3'd7, 4'd0, 56'h00000000000999, 56'h00000000000001, 56'h0, 56'h00000000001000, 1'b0, 1'b0, 4'd5},
    {5'd3,  3'd3, 4'd0, 56'h11111111111199, 56'h22222222222202, 56'h0, 56'h11111111111101, 1'b1, 1'b0, 4'd5},
    {5'd7,  3'd5, 4'd0, 56'h00000000001000, 56'h00000000002000, 56'h0, 56'h09999999999000, 1'b1, 1'b0, 4'd5},
    {5'd9,  3'd7, 4'd0, 56'h00000000000050, 56'h0, 56'h00000000000020, 56'h00000000000030, 1'b0, 1'b0, 4'd5},
    {5'd11, 3'd1, 4'd0, 56'h0, 56'h0, 56'h77777777999999, 56'h77777777000000, 1'b1, 1'b0, 4'd5},
    {5'd12, 3'd0, 4'd0, 56'h00000000300000, 56'h0, 56'h0, 56'h00000000200000, 1'b0, 1'b0, 4'd5},
    {5'd12, 3'd2, 4'd0, 56'h0, 56'h0, 56'h0, 56'h00000000000900, 1'b1, 1'b0, 4'd5},
    {5'd14, 3'd7, 4'd0, 56'h0, 56'h0, 56'h00000000000001, 56'h99999999999999, 1'b1, 1'b0, 4'd5},
    {5'd15, 3'd3, 4'd0, 56'h0, 56'h0, 56'h55555555555512, 56'h55555555555587, 1'b1, 1'b0, 4'd5},
    {5'd6,  3'd4, 4'd0, 56'h0, 56'h0, 56'h90000000000000, 56'h80000000000000, 1'b1, 1'b0, 4'd5},
    {5'd16, 3'd5, 4'd1, 56'h0, 56'h91234567890456, 56'h0, 56'h90123456789456, 1'b0, 1'b0, 4'd5},
    {5'd17, 3'd1, 4'd0, 56'h11111111123456, 56'h0, 56'h0, 56'h11111111234560, 1'b0, 1'b0, 4'd5},
    {5'd1,  3'd6, 4'd2, 56'h0, 56'h0, 56'h98765432109876, 56'h00000000000876, 1'b0, 1'b0, 4'd5},
    {5'd2,  3'd3, 4'd1, 56'h0, 56'h00000000000042, 56'h11111111111111, 56'h11111111111142, 1'b0, 1'b0, 4'd5},
    {5'd19, 3'd7, 4'd0, 56'h00000000000005, 56'h0, 56'h00000000000005, 56'h00000000000005, 1'b0, 1'b1, 4'd5},
    {5'd20, 3'd3, 4'd0, 56'h00000000000003, 56'h00000000000010, 56'h0, 56'h00000000000003, 1'b0, 1'b0, 4'd5},
    {5'd18, 3'd5, 4'd1, 56'h0, 56'h90000000000123, 56'h0, 56'h90000000000123, 1'b0, 1'b1, 4'd5},
    {5'd21, 3'd4, 4'd0, 56'h90000000000000, 56'h0, 56'h0, 56'h90000000000000, 1'b0, 1'b1, 4'd5},
    {5'd25, 3'd7, 4'd5, 56'h0, 56'h0, 56'h0, 56'h0, 1'b0, 1'b0, 4'd5},
    {5'd26, 3'd7, 4'd7, 56'h0, 56'h0, 56'h0, 56'h00000000700000, 1'b0, 1'b0, 4'd4},
    {5'd26, 3'd2, 4'd3, 56'h0, 56'h0, 56'h00000000700000, 56'h00000000730000, 1'b0, 1'b0, 4'd3},
    {5'd4,  3'd6, 4'd0, 56'h00000000005000, 56'h0, 56'h00000000005000, 56'h00000000010000, 1'b0, 1'b0, 4'd3},
    {5'd25, 3'd7, 4'd9, 56'h0, 56'h0, 56'h0, 56'h0, 1'b0, 1'b1, 4'd3}
  };
  localparam string TAG [NV] = '{
    "R9", "R2", "R4", "R3", "R3", "R2", "R1", "R3", "R3", "R3", "R2", "R5",
    "R5", "R6", "R6", "R7", "R7", "R7", "R7", "R10", "R8", "R8", "R2", "R10"
  };

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [4:0] op, input logic [2:0] fs, input logic [3:0] imm,
                       input logic [55:0] a, input logic [55:0] b, input logic [55:0] c);
    @(negedge clk);
    req_op = op; req_fs = fs; req_imm = imm;
    req_a = a; req_b = b; req_c = c;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12", "res_valid", 64'(res_valid), 64'd0);
    check("R12", "ptr", 64'(ptr), 64'd0);
    check("R12", "req_ready", 64'(req_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = TBL[i];
      issue(v[241:237], v[236:234], v[233:230], v[229:174], v[173:118], v[117:62]);
      check(TAG[i], $sformatf("row %0d word", i), 64'(res_word), 64'(v[61:6]));
      check(TAG[i], $sformatf("row %0d carry", i), 64'(res_carry), 64'(v[5]));
      check(TAG[i], $sformatf("row %0d cond", i), 64'(res_cond), 64'(v[4]));
      check(TAG[i], $sformatf("row %0d ptr", i), 64'(ptr), 64'(v[3:0]));
    end

    // R9: pointer wrap and out-of-range set
    issue(5'd22, 3'd7, 4'd13, '0, '0, '0);
    check("R9", "set 13", 64'(ptr), 64'd13);
    issue(5'd23, 3'd7, 4'd0, '0, '0, '0);
    check("R9", "inc wrap", 64'(ptr), 64'd0);
    issue(5'd24, 3'd7, 4'd0, '0, '0, '0);
    check("R9", "dec wrap", 64'(ptr), 64'd13);
    issue(5'd22, 3'd7, 4'd14, '0, '0, '0);
    check("R9", "set 14 ignored", 64'(ptr), 64'd13);
    // R8: load digit at nibble 0 wraps pointer to 13
    issue(5'd22, 3'd7, 4'd0, '0, '0, '0);
    issue(5'd26, 3'd5, 4'd9, '0, '0, 56'h11111111111110);
    check("R8", "ldc nibble 0", 64'(res_word), 64'h0011111111111119);
    check("R8", "ldc ptr wrap", 64'(ptr), 64'd13);
    // R4: exponent-sign add leaves other nibbles of A
    issue(5'd3, 3'd2, 4'd0, 56'h12345678901834, 56'h99999999999199, '0);
    check("R4", "xs add", 64'(res_word), 64'h0012345678901934);
    check("R4", "xs carry", 64'(res_carry), 64'd0);

    // R11: back-pressure
    @(negedge clk);
    res_ready = 1'b0;
    req_op = 5'd10; req_fs = 3'd7; req_imm = '0;
    req_a = 56'h00000000000041; req_b = '0; req_c = '0;
    req_valid = 1'b1;
    @(negedge clk);
    check("R11", "valid after accept", 64'(res_valid), 64'd1);
    check("R11", "ready low while stalled", 64'(req_ready), 64'd0);
    req_op = 5'd10; req_a = 56'h00000000000077;
    @(negedge clk);
    @(negedge clk);
    check("R11", "word held", 64'(res_word), 64'h42);
    check("R11", "still valid", 64'(res_valid), 64'd1);
    res_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R11", "next request taken", 64'(res_word), 64'h78);
    @(negedge clk);
    check("R11", "valid drops", 64'(res_valid), 64'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule